// File: doc/BRIEF.md
# Regulator Start-Up and Fault Sequencer

This block is the digital sequencer of a multiphase buck regulator controller. Analog ramps on external capacitors are replaced by clock-tick counters. The block watches an enable input, a supply-ok flag from the undervoltage monitor, a current-limit flag, a flag that says the soft-start level is close to the target code, and a flag that says phase detection has finished. From these it steps the regulator through its start-up intervals and drives the output controls:

- drive enable for the external gate drivers;
- PWM blanking;
- soft-start enable and soft-start rate;
- the power-good release;
- the latched shutdown flag.

One delay counter times three intervals: the start-up delay, the power-good delay and the over-current latch-off. During latch-off, a prescaler makes the counter advance only on every `SLOW_DIV`-th cycle.

At start-up the counter first times the pre-start delay. The sequencer then holds the PWM outputs blanked for a phase-detect window. It enables the slow soft-start ramp and waits for the ramp to come near the target. It then times the power-good delay at the fast ramp rate and releases power-good. Over-current is acted on only after that point. A persistent over-current ends in a shutdown that stays latched until enable drops or the supply fails.

Top module: `vreg_seq_ctrl`

## Requirements
- R1: Whenever `en_i` and `supply_ok_i` are not both high at a clock edge, the next cycle shows state OFF, timer count 0, PWM blanked, soft-start off, power-good low and drive enable low. This takes priority over every other transition.
- R2: In OFF with both enables high, the block enters TD1 on the next edge. TD1 lasts exactly `DLY_TICKS` cycles, during which the timer counts 0,1,2,… and drive enable is high.
- R3: PHASE_DET follows TD1. It keeps PWM blanked and soft-start off for at least `PH_CYCLES` cycles, and it ends only once `phase_done_i` is high (this requires `DLY_TICKS >= PH_CYCLES`).
- R4: SOFTSTART unblanks PWM and enables soft-start at the slow rate (`ss_fast_o` low). It moves to TD3 on the edge after `ss_near_i` is seen high.
- R5: TD3 lasts `DLY_TICKS` cycles with soft-start at the fast rate and power-good low. The block then enters RUN, where power-good is high, the fast rate stays selected and `ss_near_i` no longer matters.
- R6: `ilim_i` has no effect in any state before RUN.
- R7: In RUN, a high `ilim_i` moves the block to LATCHOFF on the next edge. If `ilim_i` is low at an edge in LATCHOFF, the block returns to RUN with the timer count at 0.
- R8: LATCHOFF ends in SHUTDOWN after exactly `SLOW_DIV*DLY_TICKS` cycles of continuous over-current. If `ilim_i` drops in the last of those cycles, the release wins and the block returns to RUN.
- R9: SHUTDOWN sets `shutdown_o`, blanks PWM, drops drive enable and power-good, and holds until `en_i` or `supply_ok_i` goes low.
- R10: `seq_state_o` encodes OFF=0, TD1=1, PHASE_DET=2, SOFTSTART=3, TD3=4, RUN=5, LATCHOFF=6, SHUTDOWN=7.
- R11: Synchronous active-high `rst` returns the block to OFF with timer count 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Regulator enable |
| supply_ok_i | input | 1 | Supply above lockout threshold |
| ilim_i | input | 1 | Current-limit comparator flag |
| ss_near_i | input | 1 | Soft-start level within window of target code |
| phase_done_i | input | 1 | Phase detection finished |
| seq_state_o | output | 3 | Encoded sequencer state (R10) |
| tmr_busy_o | output | 1 | Delay timer is timing an interval |
| tmr_count_o | output | CNT_W | Delay timer count |
| ss_en_o | output | 1 | Soft-start ramp enabled |
| ss_fast_o | output | 1 | Soft-start fast rate selected |
| pwm_blank_o | output | 1 | PWM outputs forced low |
| pgood_o | output | 1 | Power-good released |
| drv_on_o | output | 1 | Drive enable to gate drivers (low = outputs disabled) |
| shutdown_o | output | 1 | Latched over-current shutdown |

## Verification
Two events can fall in the same cycle: the latch-off counter reaching its threshold, and the over-current flag clearing. The bench holds `ilim_i` high for exactly one cycle less than the latch-off length, then drops it before the edge on which the shutdown would otherwise latch. The release must win: the block returns to RUN with the count at zero rather than entering SHUTDOWN. A second run with the flag held for the full length must reach SHUTDOWN, so the boundary is judged from both sides.

// File: rtl/vreg_seq_pkg.sv
package vreg_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF   = 3'd0,
        SEQ_TD1   = 3'd1,
        SEQ_PHDET = 3'd2,
        SEQ_SOFT  = 3'd3,
        SEQ_TD3   = 3'd4,
        SEQ_RUN   = 3'd5,
        SEQ_OCLAT = 3'd6,
        SEQ_SHUT  = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic pgood;
        logic drv_on;
        logic pwm_blank;
        logic ss_en;
        logic ss_fast;
        logic shutdown;
    } seq_out_t;

    typedef struct packed {
        logic clr;
        logic run;
        logic slow;
    } tmr_ctl_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // States in which the shared delay counter advances
    function automatic logic is_timed(input seq_state_e s);
        return (s == SEQ_TD1) || (s == SEQ_PHDET) || (s == SEQ_TD3) || (s == SEQ_OCLAT);
    endfunction

endpackage

// File: rtl/vreg_dly_timer.sv
module vreg_dly_timer
    import vreg_seq_pkg::*;
#(
    parameter int unsigned DLY_TICKS = 1000,
    parameter int unsigned SLOW_DIV  = 4,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    generate
        if (SLOW_DIV > 1) begin : g_pre
            localparam int unsigned PW = $clog2(SLOW_DIV);
            localparam logic [PW-1:0] PRE_LAST = PW'(SLOW_DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || ctl.clr || !ctl.run || !ctl.slow) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = ctl.run && (!ctl.slow || (pre_q == PRE_LAST));
        end else begin : g_nopre
            assign tick = ctl.run;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ctl.clr || !ctl.run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = ctl.run && tick && (cnt_q == LAST);

endmodule

// File: rtl/vreg_seq_fsm.sv
module vreg_seq_fsm
    import vreg_seq_pkg::*;
#(
    parameter int unsigned PH_CYCLES = 4,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             supply_ok_i,
    input  logic             ilim_i,
    input  logic             ss_near_i,
    input  logic             phase_done_i,
    input  logic [CNT_W-1:0] tmr_cnt_i,
    input  logic             tmr_done_i,
    output seq_state_e       state_o,
    output tmr_ctl_t         tmr_ctl_o
);

    localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(PH_CYCLES - 1);

    seq_state_e st_q, st_d;
    logic       pwr_ok;

    assign pwr_ok = en_i && supply_ok_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_OFF:   if (pwr_ok) st_d = SEQ_TD1;
            SEQ_TD1:   if (tmr_done_i) st_d = SEQ_PHDET;
            SEQ_PHDET: if ((tmr_cnt_i >= PH_LAST) && phase_done_i) st_d = SEQ_SOFT;
            SEQ_SOFT:  if (ss_near_i) st_d = SEQ_TD3;
            SEQ_TD3:   if (tmr_done_i) st_d = SEQ_RUN;
            SEQ_RUN:   if (ilim_i) st_d = SEQ_OCLAT;
            SEQ_OCLAT: begin
                if (!ilim_i) begin
                    st_d = SEQ_RUN;
                end else if (tmr_done_i) begin
                    st_d = SEQ_SHUT;
                end
            end
            SEQ_SHUT:  st_d = SEQ_SHUT;
            default:   st_d = SEQ_OFF;
        endcase
        if (!pwr_ok) begin
            st_d = SEQ_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tmr_ctl_o.run  = is_timed(st_q);
        tmr_ctl_o.slow = (st_q == SEQ_OCLAT);
        tmr_ctl_o.clr  = (st_d != st_q);
    end

    assign state_o = st_q;

endmodule

// File: rtl/vreg_seq_outdec.sv
module vreg_seq_outdec
    import vreg_seq_pkg::*;
(
    input  seq_state_e state_i,
    output seq_out_t   out_o,
    output logic       busy_o
);

    always_comb begin
        out_o = '{pgood: 1'b0, drv_on: 1'b0, pwm_blank: 1'b1,
                  ss_en: 1'b0, ss_fast: 1'b0, shutdown: 1'b0};
        unique case (state_i)
            SEQ_OFF: ;
            SEQ_TD1, SEQ_PHDET: begin
                out_o.drv_on = 1'b1;
            end
            SEQ_SOFT: begin
                out_o.drv_on    = 1'b1;
                out_o.pwm_blank = 1'b0;
                out_o.ss_en     = 1'b1;
            end
            SEQ_TD3: begin
                out_o.drv_on    = 1'b1;
                out_o.pwm_blank = 1'b0;
                out_o.ss_en     = 1'b1;
                out_o.ss_fast   = 1'b1;
            end
            SEQ_RUN, SEQ_OCLAT: begin
                out_o.pgood     = 1'b1;
                out_o.drv_on    = 1'b1;
                out_o.pwm_blank = 1'b0;
                out_o.ss_en     = 1'b1;
                out_o.ss_fast   = 1'b1;
            end
            SEQ_SHUT: begin
                out_o.shutdown = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o = is_timed(state_i);

endmodule

// File: rtl/vreg_seq_ctrl.sv
module vreg_seq_ctrl
    import vreg_seq_pkg::*;
#(
    parameter int unsigned DLY_TICKS = 1000,
    parameter int unsigned PH_CYCLES = 4,
    parameter int unsigned SLOW_DIV  = 4,
    localparam int unsigned CNT_W    = $clog2(max_u(DLY_TICKS, PH_CYCLES) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             supply_ok_i,
    input  logic             ilim_i,
    input  logic             ss_near_i,
    input  logic             phase_done_i,
    output logic [2:0]       seq_state_o,
    output logic             tmr_busy_o,
    output logic [CNT_W-1:0] tmr_count_o,
    output logic             ss_en_o,
    output logic             ss_fast_o,
    output logic             pwm_blank_o,
    output logic             pgood_o,
    output logic             drv_on_o,
    output logic             shutdown_o
);

    seq_state_e       state;
    tmr_ctl_t         tmr_ctl;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_done;
    seq_out_t         outs;

    vreg_seq_fsm #(
        .PH_CYCLES (PH_CYCLES),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_i),
        .supply_ok_i  (supply_ok_i),
        .ilim_i       (ilim_i),
        .ss_near_i    (ss_near_i),
        .phase_done_i (phase_done_i),
        .tmr_cnt_i    (tmr_cnt),
        .tmr_done_i   (tmr_done),
        .state_o      (state),
        .tmr_ctl_o    (tmr_ctl)
    );

    vreg_dly_timer #(
        .DLY_TICKS (DLY_TICKS),
        .SLOW_DIV  (SLOW_DIV),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ctl    (tmr_ctl),
        .cnt_o  (tmr_cnt),
        .done_o (tmr_done)
    );

    vreg_seq_outdec u_dec (
        .state_i (state),
        .out_o   (outs),
        .busy_o  (tmr_busy_o)
    );

    assign seq_state_o = state;
    assign tmr_count_o = tmr_cnt;
    assign ss_en_o     = outs.ss_en;
    assign ss_fast_o   = outs.ss_fast;
    assign pwm_blank_o = outs.pwm_blank;
    assign pgood_o     = outs.pgood;
    assign drv_on_o    = outs.drv_on;
    assign shutdown_o  = outs.shutdown;

endmodule

// File: rtl/vreg_seq_chk.sv
module vreg_seq_chk
    import vreg_seq_pkg::*;
#(
    parameter int unsigned DLY_TICKS = 1000,
    parameter int unsigned SLOW_DIV  = 4,
    parameter int unsigned CNT_W     = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             supply_ok_i,
    input logic             ilim_i,
    input logic [2:0]       seq_state_o,
    input logic [CNT_W-1:0] tmr_count_o,
    input logic             ss_en_o,
    input logic             pwm_blank_o,
    input logic             pgood_o,
    input logic             drv_on_o
);

    localparam int unsigned LAT_LEN = SLOW_DIV * DLY_TICKS;
    localparam int unsigned LW      = $clog2(LAT_LEN + 1) + 1;

    logic [LW-1:0] lat_cyc;

    always_ff @(posedge clk) begin
        if (rst || (seq_state_o != SEQ_OCLAT)) begin
            lat_cyc <= '0;
        end else begin
            lat_cyc <= lat_cyc + 1'b1;
        end
    end

    AST_LOCKOUT_OFF: assert property (@(posedge clk) disable iff (rst)
        !(en_i && supply_ok_i) |=> (seq_state_o == SEQ_OFF) && !pgood_o && !drv_on_o
                                   && pwm_blank_o && (tmr_count_o == '0)); // R1

    AST_PHDET_BLANK: assert property (@(posedge clk) disable iff (rst)
        (seq_state_o == SEQ_PHDET) |-> (pwm_blank_o && !ss_en_o)); // R3

    AST_PGOOD_LATE: assert property (@(posedge clk) disable iff (rst)
        pgood_o |-> ((seq_state_o == SEQ_RUN) || (seq_state_o == SEQ_OCLAT))); // R5

    AST_OC_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        (seq_state_o == SEQ_OCLAT) |-> (($past(seq_state_o) == SEQ_RUN)
                                        || ($past(seq_state_o) == SEQ_OCLAT))); // R6

    AST_OC_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((seq_state_o == SEQ_OCLAT) && !ilim_i && en_i && supply_ok_i)
        |=> ((seq_state_o == SEQ_RUN) && (tmr_count_o == '0))); // R7

    AST_LATCH_LEN: assert property (@(posedge clk) disable iff (rst)
        ((seq_state_o == SEQ_SHUT) && ($past(seq_state_o) == SEQ_OCLAT))
        |-> (lat_cyc == LW'(LAT_LEN))); // R8

    AST_SHUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((seq_state_o == SEQ_SHUT) && en_i && supply_ok_i) |=> (seq_state_o == SEQ_SHUT)); // R9

endmodule

bind vreg_seq_ctrl vreg_seq_chk #(
    .DLY_TICKS (DLY_TICKS),
    .SLOW_DIV  (SLOW_DIV),
    .CNT_W     (CNT_W)
) u_seq_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .supply_ok_i (supply_ok_i),
    .ilim_i      (ilim_i),
    .seq_state_o (seq_state_o),
    .tmr_count_o (tmr_count_o),
    .ss_en_o     (ss_en_o),
    .pwm_blank_o (pwm_blank_o),
    .pgood_o     (pgood_o),
    .drv_on_o    (drv_on_o)
);

// File: tb/test_vreg_seq_ctrl.sv
`timescale 1ns/1ps
module test_vreg_seq_ctrl;

    localparam int unsigned DLY = 8;
    localparam int unsigned CW  = 4;
    localparam int VW = 26;
    localparam int NV = 23;

    // state codes (R10)
    localparam logic [2:0] S_OFF = 3'd0, S_TD1 = 3'd1, S_PH = 3'd2, S_SS = 3'd3,
                           S_TD3 = 3'd4, S_RUN = 3'd5, S_LAT = 3'd6, S_SHUT = 3'd7;
    // outputs: pgood, drv_on, pwm_blank, ss_en, ss_fast, shutdown
    localparam logic [5:0] O_OFF = 6'b001000, O_PRE = 6'b011000, O_SS = 6'b010100,
                           O_TD3 = 6'b010110, O_RUN = 6'b110110, O_SHUT = 6'b001001;

    // {en, ok, ilim, near, pdone}, wait cycles, exp state, exp outputs, requirement
    localparam logic [VW-1:0] VEC [NV] = '{
        {5'b01001, 8'd3,  S_OFF,  O_OFF,  4'd1},  // R1 enable low
        {5'b11001, 8'd1,  S_TD1,  O_PRE,  4'd2},  // R2
        {5'b11001, 8'd7,  S_TD1,  O_PRE,  4'd2},  // R2 last TD1 cycle
        {5'b11001, 8'd1,  S_PH,   O_PRE,  4'd2},  // R2 TD1 over
        {5'b11001, 8'd3,  S_PH,   O_PRE,  4'd3},  // R3 minimum window
        {5'b11001, 8'd1,  S_SS,   O_SS,   4'd3},  // R3 exit after window
        {5'b11101, 8'd5,  S_SS,   O_SS,   4'd6},  // R6 ilim ignored
        {5'b11011, 8'd1,  S_TD3,  O_TD3,  4'd4},  // R4 near -> TD3
        {5'b11011, 8'd7,  S_TD3,  O_TD3,  4'd5},  // R5
        {5'b11011, 8'd1,  S_RUN,  O_RUN,  4'd5},  // R5 power-good
        {5'b11001, 8'd3,  S_RUN,  O_RUN,  4'd5},  // R5 near drop ignored
        {5'b11101, 8'd1,  S_LAT,  O_RUN,  4'd7},  // R7
        {5'b11101, 8'd10, S_LAT,  O_RUN,  4'd8},  // R8
        {5'b11001, 8'd1,  S_RUN,  O_RUN,  4'd7},  // R7 release
        {5'b11101, 8'd1,  S_LAT,  O_RUN,  4'd7},  // R7
        {5'b11101, 8'd31, S_LAT,  O_RUN,  4'd8},  // R8 one short
        {5'b11101, 8'd1,  S_SHUT, O_SHUT, 4'd8},  // R8 full length
        {5'b11001, 8'd5,  S_SHUT, O_SHUT, 4'd9},  // R9 sticky
        {5'b01001, 8'd1,  S_OFF,  O_OFF,  4'd9},  // R9 cleared by enable
        {5'b11000, 8'd9,  S_PH,   O_PRE,  4'd3},  // R3 no done flag
        {5'b11000, 8'd10, S_PH,   O_PRE,  4'd3},  // R3 waits for flag
        {5'b11001, 8'd1,  S_SS,   O_SS,   4'd3},  // R3
        {5'b10001, 8'd1,  S_OFF,  O_OFF,  4'd1}   // R1 supply lost
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, ok = 1'b0, ilim = 1'b0, near = 1'b0, pdone = 1'b0;
    logic [2:0]    st;
    logic          busy;
    logic [CW-1:0] cnt;
    logic ss_en, ss_fast, blank, pg, drv, shut;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vreg_seq_ctrl #(.DLY_TICKS(DLY), .PH_CYCLES(4), .SLOW_DIV(4)) i_vreg_seq_ctrl (
        .clk(clk), .rst(rst), .en_i(en), .supply_ok_i(ok), .ilim_i(ilim),
        .ss_near_i(near), .phase_done_i(pdone), .seq_state_o(st), .tmr_busy_o(busy),
        .tmr_count_o(cnt), .ss_en_o(ss_en), .ss_fast_o(ss_fast), .pwm_blank_o(blank),
        .pgood_o(pg), .drv_on_o(drv), .shutdown_o(shut)
    );

    function automatic logic [8:0] obs();
        return {st, pg, drv, blank, ss_en, ss_fast, shut};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        check("R11 reset state", 32'(obs()), 32'({S_OFF, O_OFF}));
        check("R11 reset count", 32'(cnt), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            {en, ok, ilim, near, pdone} = v[25:21];
            wait_n(int'(v[20:13]));
            check($sformatf("R%0d vector %0d", v[3:0], i), 32'(obs()), 32'(v[12:4]));
        end

        // R2 timer progress during TD1
        en = 1'b1; ok = 1'b1; near = 1'b1; pdone = 1'b1; ilim = 1'b0;
        wait_n(6);
        check("R2 TD1 count", 32'({st, busy, cnt}), 32'({S_TD1, 1'b1, 4'd5}));
        wait_n(16);
        check("R5 RUN timer idle", 32'({st, busy, cnt}), 32'({S_RUN, 1'b0, 4'd0}));

        // R8 collision: ilim drops in final latch-off cycle
        ilim = 1'b1;
        wait_n(32);
        check("R8 last latch-off cycle", 32'(st), 32'(S_LAT));
        ilim = 1'b0;
        wait_n(1);
        check("R8 release wins", 32'({st, cnt}), 32'({S_RUN, 4'd0}));

        // full latch-off then supply lockout clears it
        ilim = 1'b1;
        wait_n(33);
        check("R8 shutdown latched", 32'(obs()), 32'({S_SHUT, O_SHUT}));
        ok = 1'b0;
        wait_n(1);
        check("R9 lockout clears", 32'(obs()), 32'({S_OFF, O_OFF}));

        // R11 reset in RUN
        ilim = 1'b0; ok = 1'b1;
        wait_n(22);
        check("R5 restart", 32'(st), 32'(S_RUN));
        rst = 1'b1;
        wait_n(1);
        check("R11 reset from RUN", 32'({obs(), cnt}), 32'({S_OFF, O_OFF, 4'd0}));
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1..R11 act=hung exp=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule